// File: doc/BRIEF.md
# Sixteen-Bit ALU With Overflow Word

This block is the arithmetic and compare stage of a small 16-bit processor. Each operation is issued with a one-cycle `start` pulse that carries a 5-bit opcode, the two operand words and the current value of the overflow word. The block returns the new value for the first operand and the new overflow word, together with a write strobe for the overflow word. It also returns a pass/fail flag for the test opcodes and the number of processor cycles the operation is charged. Arithmetic and shift operations write a companion word: a carry or borrow marker, the upper half of a product, the binary fraction of a quotient, or the bits shifted out.

Most operations finish in the clock after `start`. Divide and remainder with a nonzero divisor run on a shared iterative divider, and `busy` stays high while it runs. A `start` pulse that arrives while `busy` is high is dropped. Fetching operands, updating the program counter and skipping instructions are handled by the surrounding pipeline.

Top module: `ovf_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done`, `busy`, `result`, `ex_out`, `ex_we`, `cond` and `cycles` all go to zero.
- R2: Opcode 0x02 (add) returns (a+b) mod 2^16 and writes 0x0001 to the overflow word on an unsigned carry, else 0x0000. Opcode 0x03 (subtract) returns (a-b) mod 2^16 and writes 0xFFFF when b>a, else 0x0000.
- R3: Opcode 0x04 returns the low half of the unsigned 32-bit product and writes the high half to the overflow word. Opcode 0x05 does the same with both operands taken as two's-complement.
- R4: Opcode 0x06 returns floor(a/b) and writes the low 16 bits of floor(a*65536/b). Opcode 0x07 does the same on two's-complement values, with both quotients truncated toward zero.
- R5: Opcode 0x08 returns a mod b (unsigned) and does not write the overflow word.
- R6: With b equal to zero, opcodes 0x06 and 0x07 return 0 and write 0 to the overflow word, and opcode 0x08 returns 0 without writing it. All three finish in the clock after `start`.
- R7: Opcode 0x0C (logical right shift) returns a>>b and writes bits 15..0 of ({a,16'h0}>>b). Opcode 0x0D (arithmetic right shift) does the same with sign fill. Opcode 0x0E (left shift) returns a<<b and writes bits 31..16 of ({16'h0,a}<<b). Shift counts of 16 and above are honoured in full, so 16 and above gives 0 (or all sign bits) and 32 and above gives 0 (or all sign bits) in the overflow word as well.
- R8: Opcodes 0x01 (copy b), 0x09 (AND), 0x0A (OR) and 0x0B (XOR) return the stated value. They, and every opcode that does not write the overflow word, hold `ex_we` low with `ex_out` equal to the `ex_in` given at `start`.
- R9: For test opcodes 0x11..0x17 `cond` is, in order: (a&b)!=0, a==b, a!=b, signed a>b, unsigned a>b, signed a<b, unsigned a<b. For every other opcode `cond` is 0.
- R10: `cycles` reports 1 for 0x01 and 0x09..0x0B, 2 for 0x02..0x05 and 0x0C..0x0E, 3 for 0x06..0x08, and 2 (flag set) or 3 (flag clear) for 0x11..0x17.
- R11: `done` pulses for one cycle per accepted `start`. It is visible in the clock after `start` for every opcode except 0x06..0x08 with a nonzero divisor, which take 2*W+1 clocks with `busy` high and `done` low until the last one. A `start` seen while `busy` is high is ignored.
- R12: Opcodes 0x00, 0x0F, 0x10 and 0x18..0x1F return a unchanged, with `cond` 0, no overflow-word write and `cycles` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Issue pulse, operands valid in this cycle |
| opcode | input | 5 | Operation code |
| op_a | input | 16 | First operand (destination value) |
| op_b | input | 16 | Second operand |
| ex_in | input | 16 | Current overflow word |
| busy | output | 1 | Divider running, new starts are dropped |
| done | output | 1 | Result outputs valid this cycle |
| result | output | 16 | New value for the first operand |
| ex_out | output | 16 | New overflow word |
| ex_we | output | 1 | Overflow word is written |
| cond | output | 1 | Test outcome for 0x11..0x17 |
| cycles | output | 2 | Cycle cost charged to the operation |

## Verification
The assertions check on every cycle that `done` has a cause, that it stays low while the divider is busy, and that the flag and overflow strobe only appear for opcodes that may raise them. They also check that a zero divisor produces zeros and that the divider's remainder stays below its divisor. The numerical values are shown only by the bench's scenarios, which compare each result against an independent integer model. These values include carry and borrow words, signed product halves, truncated signed quotients with their fractions, shift counts past 16 and 32, and every test predicate on both outcomes. Only the scenarios show the exact divider latency and that a start issued mid-divide is dropped.

// File: rtl/ovf_alu_pkg.sv
// Package: opcode values, cycle costs and opcode class helpers shared by
// the ALU modules. Assumes a 5-bit opcode field.
package ovf_alu_pkg;

    localparam int unsigned OPW = 5;
    localparam int unsigned CYW = 2;

    localparam logic [OPW-1:0] OP_MOVE = 5'h01;
    localparam logic [OPW-1:0] OP_ADD  = 5'h02;
    localparam logic [OPW-1:0] OP_SUB  = 5'h03;
    localparam logic [OPW-1:0] OP_MULU = 5'h04;
    localparam logic [OPW-1:0] OP_MULS = 5'h05;
    localparam logic [OPW-1:0] OP_DIVU = 5'h06;
    localparam logic [OPW-1:0] OP_DIVS = 5'h07;
    localparam logic [OPW-1:0] OP_REM  = 5'h08;
    localparam logic [OPW-1:0] OP_AND  = 5'h09;
    localparam logic [OPW-1:0] OP_OR   = 5'h0A;
    localparam logic [OPW-1:0] OP_XOR  = 5'h0B;
    localparam logic [OPW-1:0] OP_SRL  = 5'h0C;
    localparam logic [OPW-1:0] OP_SRA  = 5'h0D;
    localparam logic [OPW-1:0] OP_SLL  = 5'h0E;
    localparam logic [OPW-1:0] OP_TBIT = 5'h11;
    localparam logic [OPW-1:0] OP_TEQ  = 5'h12;
    localparam logic [OPW-1:0] OP_TNE  = 5'h13;
    localparam logic [OPW-1:0] OP_TGTS = 5'h14;
    localparam logic [OPW-1:0] OP_TGTU = 5'h15;
    localparam logic [OPW-1:0] OP_TLTS = 5'h16;
    localparam logic [OPW-1:0] OP_TLTU = 5'h17;

    localparam logic [CYW-1:0] CYC_ONE   = 2'd1;
    localparam logic [CYW-1:0] CYC_TWO   = 2'd2;
    localparam logic [CYW-1:0] CYC_THREE = 2'd3;

    // True for the opcodes served by the iterative divider.
    function automatic logic is_div(input logic [OPW-1:0] op);
        return (op == OP_DIVU) || (op == OP_DIVS) || (op == OP_REM);
    endfunction

    // True for the opcodes that may write the overflow word.
    function automatic logic writes_ex(input logic [OPW-1:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MULU) ||
               (op == OP_MULS) || (op == OP_DIVU) || (op == OP_DIVS) ||
               (op == OP_SRL) || (op == OP_SRA) || (op == OP_SLL);
    endfunction

    // True for the conditional test opcodes.
    function automatic logic is_test(input logic [OPW-1:0] op);
        return (op >= OP_TBIT) && (op <= OP_TLTU);
    endfunction

endpackage

// File: rtl/ovf_alu_fast.sv
// Module: single-cycle datapath. Computes result, overflow word, write
// strobe, test flag and cycle cost for every opcode in one pass of logic.
// Divide opcodes produce their zero-divisor outcome here; the top module
// uses that only when b is zero. Assumes W >= 2.
module ovf_alu_fast
    import ovf_alu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic [W-1:0]   ex_val,
    output logic           ex_wr,
    output logic           cond,
    output logic [CYW-1:0] cyc
);
    localparam int unsigned DW  = 2 * W;
    localparam int unsigned SHW = $clog2(DW) + 1;

    logic [SHW-1:0]       sh;
    logic [DW-1:0]        wide;
    logic [DW-1:0]        srl_w;
    logic signed [DW-1:0] sra_w;
    logic [DW-1:0]        sll_w;
    logic [W:0]           sum;
    logic [W:0]           diff;
    logic [DW-1:0]        prod_u;
    logic [DW-1:0]        prod_s;

    // Shift count saturated at DW so the shifters stay SHW bits wide.
    always_comb sh = (b >= W'(DW)) ? SHW'(DW) : b[SHW-1:0];

    // Double-width shifters: upper half gives the result, lower half the spill.
    always_comb begin
        wide  = {a, {W{1'b0}}};
        srl_w = wide >> sh;
        sra_w = $signed(wide) >>> sh;
        sll_w = {{W{1'b0}}, a} << sh;
    end

    // Adder, subtractor and both multipliers.
    always_comb begin
        sum    = {1'b0, a} + {1'b0, b};
        diff   = {1'b0, a} - {1'b0, b};
        prod_u = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        prod_s = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
    end

    // Opcode select for all outputs.
    always_comb begin
        res    = a;
        ex_val = '0;
        ex_wr  = 1'b0;
        cond   = 1'b0;
        cyc    = CYC_ONE;
        case (op)
            OP_MOVE: res = b;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_ADD: begin
                res = sum[W-1:0]; ex_wr = 1'b1; cyc = CYC_TWO;
                ex_val = sum[W] ? W'(1) : '0;
            end
            OP_SUB: begin
                res = diff[W-1:0]; ex_wr = 1'b1; cyc = CYC_TWO;
                ex_val = diff[W] ? '1 : '0;
            end
            OP_MULU: begin
                res = prod_u[W-1:0]; ex_val = prod_u[DW-1:W];
                ex_wr = 1'b1; cyc = CYC_TWO;
            end
            OP_MULS: begin
                res = prod_s[W-1:0]; ex_val = prod_s[DW-1:W];
                ex_wr = 1'b1; cyc = CYC_TWO;
            end
            OP_SRL: begin
                res = srl_w[DW-1:W]; ex_val = srl_w[W-1:0];
                ex_wr = 1'b1; cyc = CYC_TWO;
            end
            OP_SRA: begin
                res = sra_w[DW-1:W]; ex_val = sra_w[W-1:0];
                ex_wr = 1'b1; cyc = CYC_TWO;
            end
            OP_SLL: begin
                res = sll_w[W-1:0]; ex_val = sll_w[DW-1:W];
                ex_wr = 1'b1; cyc = CYC_TWO;
            end
            OP_DIVU, OP_DIVS: begin
                res = '0; ex_wr = 1'b1; cyc = CYC_THREE;
            end
            OP_REM: begin
                res = '0; cyc = CYC_THREE;
            end
            OP_TBIT: cond = (a & b) != '0;
            OP_TEQ:  cond = (a == b);
            OP_TNE:  cond = (a != b);
            OP_TGTS: cond = $signed(a) > $signed(b);
            OP_TGTU: cond = a > b;
            OP_TLTS: cond = $signed(a) < $signed(b);
            OP_TLTU: cond = a < b;
            default: ;
        endcase
        if (is_test(op)) begin
            res = a;
            cyc = cond ? CYC_TWO : CYC_THREE;
        end
    end
endmodule

// File: rtl/ovf_alu_divider.sv
// Module: restoring divider, one quotient bit per clock. Divides a DW-bit
// dividend by a W-bit divisor in DW steps; fin pulses when quot and rem are
// valid. A go pulse while a division runs is ignored. Assumes the caller
// never starts it with a zero divisor.
module ovf_alu_divider #(
    parameter int unsigned W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [2*W-1:0]  dividend,
    input  logic [W-1:0]    divisor,
    output logic            fin,
    output logic [2*W-1:0]  quot,
    output logic [W-1:0]    rem
);
    localparam int unsigned DW = 2 * W;
    localparam int unsigned CW = $clog2(DW);

    logic          busy_r;
    logic [CW-1:0] cnt_r;
    logic [DW-1:0] quo_r;
    logic [W-1:0]  rem_r;
    logic [W-1:0]  dvs_r;
    logic          fin_r;
    logic [W:0]    trial;
    logic          take;
    logic [W-1:0]  nxt_rem;

    // One restoring step: shift in the next dividend bit and try to subtract.
    always_comb begin
        trial   = {rem_r, quo_r[DW-1]};
        take    = trial >= {1'b0, dvs_r};
        nxt_rem = take ? W'(trial - {1'b0, dvs_r}) : trial[W-1:0];
    end

    // Step sequencer: load on go, iterate DW times, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_r <= 1'b0;
            cnt_r  <= '0;
            quo_r  <= '0;
            rem_r  <= '0;
            dvs_r  <= '0;
            fin_r  <= 1'b0;
        end else begin
            fin_r <= 1'b0;
            if (go && !busy_r) begin
                busy_r <= 1'b1;
                cnt_r  <= '0;
                quo_r  <= dividend;
                rem_r  <= '0;
                dvs_r  <= divisor;
            end else if (busy_r) begin
                quo_r <= {quo_r[DW-2:0], take};
                rem_r <= nxt_rem;
                cnt_r <= cnt_r + 1'b1;
                if (cnt_r == CW'(DW - 1)) begin
                    busy_r <= 1'b0;
                    fin_r  <= 1'b1;
                end
            end
        end
    end

    assign fin  = fin_r;
    assign quot = quo_r;
    assign rem  = rem_r;

    // A finished remainder is always smaller than its divisor (R4, R5).
    p_rem_below_divisor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_r && dvs_r != '0) |-> (rem_r < dvs_r));

    // Completion only follows a running division (R11).
    p_fin_after_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fin_r |-> $past(busy_r));
endmodule

// File: rtl/ovf_alu.sv
// Module: top of the 16-bit ALU with overflow word. Accepts one operation
// per start pulse when idle, answers single-cycle opcodes in the next clock
// and routes divide/remainder with a nonzero divisor through the iterative
// divider, then registers result, overflow word, strobe, flag and cost.
// Assumes start is a pulse and inputs are valid in the start cycle.
module ovf_alu
    import ovf_alu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [4:0]     opcode,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic [W-1:0]   ex_in,
    output logic           busy,
    output logic           done,
    output logic [W-1:0]   result,
    output logic [W-1:0]   ex_out,
    output logic           ex_we,
    output logic           cond,
    output logic [1:0]     cycles
);
    localparam int unsigned DW = 2 * W;

    logic [W-1:0]   f_res, f_ex;
    logic           f_exwr, f_cond;
    logic [CYW-1:0] f_cyc;
    logic           div_go, div_fin;
    logic [DW-1:0]  div_dividend, div_quot;
    logic [W-1:0]   div_divisor, div_rem;
    logic [W-1:0]   a_mag, b_mag, q_hi, q_lo;

    logic           busy_q, done_q, exwe_q, cond_q, neg_q;
    logic [W-1:0]   res_q, ex_q, ex_hold_q, b_q;
    logic [CYW-1:0] cyc_q;
    logic [OPW-1:0] op_q;
    logic           accept;

    ovf_alu_fast #(.W(W)) u_fast (
        .op(opcode), .a(op_a), .b(op_b),
        .res(f_res), .ex_val(f_ex), .ex_wr(f_exwr), .cond(f_cond), .cyc(f_cyc)
    );

    // Operand conditioning for the divider: magnitudes for signed divide,
    // a plain W-bit dividend for remainder, a scaled dividend otherwise.
    always_comb begin
        a_mag  = op_a[W-1] ? -op_a : op_a;
        b_mag  = op_b[W-1] ? -op_b : op_b;
        accept = start && !busy_q;
        div_go = accept && is_div(opcode) && (op_b != '0);
        if (opcode == OP_REM) begin
            div_dividend = {{W{1'b0}}, op_a};
            div_divisor  = op_b;
        end else if (opcode == OP_DIVS) begin
            div_dividend = {a_mag, {W{1'b0}}};
            div_divisor  = b_mag;
        end else begin
            div_dividend = {op_a, {W{1'b0}}};
            div_divisor  = op_b;
        end
    end

    ovf_alu_divider #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .dividend(div_dividend), .divisor(div_divisor),
        .fin(div_fin), .quot(div_quot), .rem(div_rem)
    );

    // Sign restoration of both quotient halves for signed divide.
    always_comb begin
        q_hi = neg_q ? -div_quot[DW-1:W] : div_quot[DW-1:W];
        q_lo = neg_q ? -div_quot[W-1:0]  : div_quot[W-1:0];
    end

    // Issue control and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            res_q     <= '0;
            ex_q      <= '0;
            exwe_q    <= 1'b0;
            cond_q    <= 1'b0;
            cyc_q     <= '0;
            op_q      <= '0;
            b_q       <= '0;
            neg_q     <= 1'b0;
            ex_hold_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                op_q <= opcode;
                b_q  <= op_b;
                if (div_go) begin
                    busy_q    <= 1'b1;
                    neg_q     <= (opcode == OP_DIVS) && (op_a[W-1] ^ op_b[W-1]);
                    ex_hold_q <= ex_in;
                end else begin
                    done_q <= 1'b1;
                    res_q  <= f_res;
                    ex_q   <= f_exwr ? f_ex : ex_in;
                    exwe_q <= f_exwr;
                    cond_q <= f_cond;
                    cyc_q  <= f_cyc;
                end
            end else if (busy_q && div_fin) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                cond_q <= 1'b0;
                cyc_q  <= CYC_THREE;
                if (op_q == OP_REM) begin
                    res_q  <= div_rem;
                    ex_q   <= ex_hold_q;
                    exwe_q <= 1'b0;
                end else begin
                    res_q  <= q_hi;
                    ex_q   <= q_lo;
                    exwe_q <= 1'b1;
                end
            end
        end
    end

    assign busy   = busy_q;
    assign done   = done_q;
    assign result = res_q;
    assign ex_out = ex_q;
    assign ex_we  = exwe_q;
    assign cond   = cond_q;
    assign cycles = cyc_q;

    // Every done traces to an accepted start or a divider completion (R11).
    p_done_has_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(start && !busy_q) || $past(div_fin)));

    // No result is presented while the divider still runs (R11).
    p_quiet_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !done_q);

    // A completed operation always carries a nonzero cost (R10).
    p_cost_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (cyc_q != '0));

    // The flag is only raised by a test opcode (R9).
    p_flag_only_tests_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && cond_q) |-> is_test(op_q));

    // The overflow strobe only comes from overflow-writing opcodes (R8).
    p_ex_strobe_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && exwe_q) |-> writes_ex(op_q));

    // Remainder never writes the overflow word (R5).
    p_rem_keeps_ex_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && op_q == OP_REM) |-> !exwe_q);

    // Zero divisor yields zero result and zero overflow word (R6).
    p_zero_divisor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && is_div(op_q) && b_q == '0) |->
            ((res_q == '0) && (!exwe_q || ex_q == '0)));
endmodule

// File: tb/test_ovf_alu.sv
module test_ovf_alu;
    localparam int W = 16;
    localparam int DIV_LAT = 2 * W + 1;

    typedef struct packed {
        logic [15:0] res;
        logic [15:0] ex;
        logic        we;
        logic        cond;
        logic [1:0]  cyc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  opcode = '0;
    logic [15:0] op_a = '0, op_b = '0, ex_in = '0;
    logic        busy, done, ex_we, cond;
    logic [15:0] result, ex_out;
    logic [1:0]  cycles;

    int total = 0;
    int bad = 0;
    int cyc_cnt = 0;

    exp_t  exp_q[$];
    int    lat_q[$];
    int    t_q[$];
    string tag_q[$];

    ovf_alu #(.W(W)) i_ovf_alu (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .ex_in(ex_in),
        .busy(busy), .done(done), .result(result), .ex_out(ex_out),
        .ex_we(ex_we), .cond(cond), .cycles(cycles)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    function automatic exp_t model(input logic [4:0] op, input logic [15:0] a,
                                   input logic [15:0] b, input logic [15:0] exi);
        exp_t e;
        longint ua, ub, sa, sb, t;
        logic [31:0] w32, z32;
        logic signed [31:0] ws;
        logic signed [15:0] a16;
        ua = longint'(a); ub = longint'(b);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        e.res = a; e.ex = exi; e.we = 1'b0; e.cond = 1'b0; e.cyc = 2'd1;
        case (op)
            5'h01: e.res = b;
            5'h09: e.res = a & b;
            5'h0A: e.res = a | b;
            5'h0B: e.res = a ^ b;
            5'h02: begin t = ua + ub; e.res = t[15:0]; e.we = 1; e.cyc = 2;
                         e.ex = (t > 65535) ? 16'h0001 : 16'h0000; end
            5'h03: begin t = ua - ub; e.res = t[15:0]; e.we = 1; e.cyc = 2;
                         e.ex = (ub > ua) ? 16'hFFFF : 16'h0000; end
            5'h04: begin t = ua * ub; e.res = t[15:0]; e.ex = t[31:16]; e.we = 1; e.cyc = 2; end
            5'h05: begin t = sa * sb; e.res = t[15:0]; e.ex = t[31:16]; e.we = 1; e.cyc = 2; end
            5'h06: begin e.we = 1; e.cyc = 3;
                if (ub == 0) begin e.res = 0; e.ex = 0; end
                else begin t = ua / ub; e.res = t[15:0]; t = (ua * 65536) / ub; e.ex = t[15:0]; end
            end
            5'h07: begin e.we = 1; e.cyc = 3;
                if (sb == 0) begin e.res = 0; e.ex = 0; end
                else begin t = sa / sb; e.res = t[15:0]; t = (sa * 65536) / sb; e.ex = t[15:0]; end
            end
            5'h08: begin e.cyc = 3; t = (ub == 0) ? 0 : ua % ub; e.res = t[15:0]; end
            5'h0C: begin w32 = {a, 16'h0}; z32 = w32 >> b; e.ex = z32[15:0];
                         e.res = a >> b; e.we = 1; e.cyc = 2; end
            5'h0D: begin ws = {a, 16'h0}; ws = ws >>> b; e.ex = ws[15:0];
                         a16 = a; a16 = a16 >>> b; e.res = a16; e.we = 1; e.cyc = 2; end
            5'h0E: begin z32 = {16'h0, a} << b; e.res = z32[15:0]; e.ex = z32[31:16];
                         e.we = 1; e.cyc = 2; end
            5'h11: e.cond = (a & b) != 0;
            5'h12: e.cond = (ua == ub);
            5'h13: e.cond = (ua != ub);
            5'h14: e.cond = (sa > sb);
            5'h15: e.cond = (ua > ub);
            5'h16: e.cond = (sa < sb);
            5'h17: e.cond = (ua < ub);
            default: ;
        endcase
        if (op >= 5'h11 && op <= 5'h17) e.cyc = e.cond ? 2'd2 : 2'd3;
        return e;
    endfunction

    // Driver: called at a negedge; pushes the expectation and pulses start.
    task automatic issue(input logic [4:0] op, input logic [15:0] a,
                         input logic [15:0] b, input logic [15:0] exi, input string tag);
        bit slow;
        slow = (op >= 5'h06 && op <= 5'h08) && (b != 0);
        exp_q.push_back(model(op, a, b, exi));
        lat_q.push_back(slow ? DIV_LAT : 0);
        t_q.push_back(cyc_cnt + 1);
        tag_q.push_back(tag);
        opcode = op; op_a = a; op_b = b; ex_in = exi; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ex_in = 16'hDEAD;
        while (busy) @(negedge clk);
    endtask

    // Monitor: pops an expectation for every done and compares.
    always @(negedge clk) begin
        if (rst_n && done) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected done: actual res=%h expected no result", result);
            end else begin
                exp_t e;
                int lat, t;
                string tg;
                e = exp_q.pop_front(); lat = lat_q.pop_front();
                t = t_q.pop_front(); tg = tag_q.pop_front();
                if (result !== e.res || ex_out !== e.ex || ex_we !== e.we ||
                    cond !== e.cond || cycles !== e.cyc) begin
                    bad++;
                    $display("FAIL %s actual res=%h ex=%h we=%b cond=%b cyc=%0d expected res=%h ex=%h we=%b cond=%b cyc=%0d",
                             tg, result, ex_out, ex_we, cond, cycles, e.res, e.ex, e.we, e.cond, e.cyc);
                end
                total++;
                if (cyc_cnt - t != lat) begin
                    bad++;
                    $display("FAIL R11 latency (%s) actual=%0d expected=%0d", tg, cyc_cnt - t, lat);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        total++;
        if (done !== 0 || busy !== 0 || result !== 0 || ex_out !== 0 ||
            ex_we !== 0 || cond !== 0 || cycles !== 0) begin
            bad++;
            $display("FAIL R1 actual done=%b busy=%b res=%h ex=%h we=%b cond=%b cyc=%0d expected all zero",
                     done, busy, result, ex_out, ex_we, cond, cycles);
        end
        rst_n = 1'b1;
        @(negedge clk);

        issue(5'h01, 16'h1234, 16'hBEEF, 16'h5555, "R8");
        issue(5'h09, 16'hF0F0, 16'h3C3C, 16'hAAAA, "R8");
        issue(5'h0A, 16'hF0F0, 16'h0F01, 16'h0001, "R8");
        issue(5'h0B, 16'hFFFF, 16'h1234, 16'h7777, "R8");
        issue(5'h02, 16'h1234, 16'h0001, 16'h9999, "R2");
        issue(5'h02, 16'hCCDD, 16'h5678, 16'h0000, "R2");
        issue(5'h03, 16'h0030, 16'h0020, 16'h1111, "R2");
        issue(5'h03, 16'h0001, 16'h0002, 16'h0000, "R2");
        issue(5'h04, 16'hFFFF, 16'hFFFF, 16'h0000, "R3");
        issue(5'h04, 16'h0123, 16'h0456, 16'h0000, "R3");
        issue(5'h05, 16'hFFFE, 16'h0003, 16'h0000, "R3");
        issue(5'h05, 16'h8000, 16'h8000, 16'h0000, "R3");
        issue(5'h06, 16'h0007, 16'h0002, 16'h4444, "R4");
        issue(5'h06, 16'h0001, 16'h0003, 16'h4444, "R4");
        issue(5'h07, 16'hFFFF, 16'h0002, 16'h4444, "R4");
        issue(5'h07, 16'hFFF9, 16'h0003, 16'h4444, "R4");
        issue(5'h07, 16'h8000, 16'hFFFF, 16'h4444, "R4");
        issue(5'h07, 16'h0064, 16'hFFF9, 16'h4444, "R4");
        issue(5'h08, 16'h0064, 16'h0007, 16'h6161, "R5");
        issue(5'h08, 16'hFFFF, 16'h0100, 16'h6161, "R5");
        issue(5'h06, 16'h1234, 16'h0000, 16'h5A5A, "R6");
        issue(5'h07, 16'h8001, 16'h0000, 16'h5A5A, "R6");
        issue(5'h08, 16'h1234, 16'h0000, 16'h5A5A, "R6");
        issue(5'h0C, 16'h8421, 16'h0004, 16'h0000, "R7");
        issue(5'h0C, 16'h8421, 16'h0010, 16'h0000, "R7");
        issue(5'h0C, 16'h8421, 16'h0014, 16'h0000, "R7");
        issue(5'h0C, 16'h8421, 16'h0028, 16'h0000, "R7");
        issue(5'h0D, 16'h8421, 16'h0004, 16'h0000, "R7");
        issue(5'h0D, 16'h8421, 16'h0014, 16'h0000, "R7");
        issue(5'h0D, 16'h8421, 16'h0100, 16'h0000, "R7");
        issue(5'h0D, 16'h4421, 16'h0003, 16'h0000, "R7");
        issue(5'h0E, 16'h0004, 16'h0004, 16'h0000, "R7");
        issue(5'h0E, 16'hABCD, 16'h000C, 16'h0000, "R7");
        issue(5'h0E, 16'hABCD, 16'h0014, 16'h0000, "R7");
        issue(5'h0E, 16'hABCD, 16'h0021, 16'h0000, "R7");
        issue(5'h11, 16'h0F00, 16'h0100, 16'h3333, "R9 R10");
        issue(5'h11, 16'h0F00, 16'h00F0, 16'h3333, "R9 R10");
        issue(5'h12, 16'h0042, 16'h0042, 16'h3333, "R9 R10");
        issue(5'h12, 16'h0042, 16'h0043, 16'h3333, "R9 R10");
        issue(5'h13, 16'h0010, 16'h0010, 16'h3333, "R9 R10");
        issue(5'h13, 16'h0010, 16'h0011, 16'h3333, "R9 R10");
        issue(5'h14, 16'h0001, 16'hFFFF, 16'h3333, "R9 R10");
        issue(5'h14, 16'hFFFF, 16'h0001, 16'h3333, "R9 R10");
        issue(5'h15, 16'hFFFF, 16'h0001, 16'h3333, "R9 R10");
        issue(5'h15, 16'h0001, 16'hFFFF, 16'h3333, "R9 R10");
        issue(5'h16, 16'h8000, 16'h7FFF, 16'h3333, "R9 R10");
        issue(5'h16, 16'h7FFF, 16'h8000, 16'h3333, "R9 R10");
        issue(5'h17, 16'h0005, 16'h0006, 16'h3333, "R9 R10");
        issue(5'h17, 16'h0006, 16'h0006, 16'h3333, "R9 R10");
        issue(5'h00, 16'h1357, 16'h2468, 16'h0F0F, "R12");
        issue(5'h0F, 16'h1357, 16'h2468, 16'h0F0F, "R12");
        issue(5'h10, 16'h1357, 16'h2468, 16'h0F0F, "R12");
        issue(5'h1F, 16'hFFFF, 16'hFFFF, 16'h0F0F, "R12");

        // R11: a start during a running divide is dropped.
        exp_q.push_back(model(5'h06, 16'h9000, 16'h0007, 16'h2222));
        lat_q.push_back(DIV_LAT);
        t_q.push_back(cyc_cnt + 1);
        tag_q.push_back("R11");
        opcode = 5'h06; op_a = 16'h9000; op_b = 16'h0007; ex_in = 16'h2222; start = 1'b1;
        @(negedge clk);
        opcode = 5'h01; op_a = 16'h0BAD; op_b = 16'h0BAD; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        issue(5'h02, 16'hFFFF, 16'hFFFF, 16'h0000, "R11 R2");

        repeat (5) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R11 pending results actual=%0d expected=0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule